// File: doc/BRIEF.md
# Staircase Gate Pattern Generator for a Five-Level Single-Phase Inverter

This block drives the six gate signals of a reduced-switch, five-level, single-phase inverter that switches at the fundamental frequency. A phase register sweeps one fundamental period in fine angle steps. The period is cut into voltage levels from -2 to +2, and each level is decoded into a fixed six-bit gate word. On every running clock the phase moves forward by a frequency tuning word, so the tuning word sets the output frequency as a fraction of the clock.

Three timing schemes set how long each level lasts. Every half-cycle has five symmetric segments: zero, one step, two steps, one step, zero. The segment lengths are multiples of a unit angle. Scheme I uses 1:1:2:1:1 with a 30-degree unit, scheme II uses 1:2:4:2:1 with an 18-degree unit, and scheme III uses 1:2:6:2:1 with a 15-degree unit. The second half-cycle repeats the first with the signs reversed. A new scheme selection is held back until the period wraps, so a period never mixes two schemes. Dropping the enable parks the phase at zero and turns every gate off.

Top module: `staircase_gate_gen`

## Requirements
- R1: While reset is asserted, and on the first clock after it, all six gate outputs and the level code are 0. Reset leaves the phase at 0 and the active scheme at I.
- R2: A clock edge with enable low clears every gate output, the level code and the phase. The first running cycle after enable rises shows phase 0.
- R3: In every running cycle with enable high, the 16-bit phase advances by the tuning word modulo 2^16, where 2^16 counts stand for 360 degrees.
- R4: In scheme I, the magnitude within a half-cycle offset r (phase mod 32768) is 0 below 5461, 1 below 10923, 2 below 21845, 1 below 27307, and 0 from there on. Each boundary is the unit-multiple angle rounded to the nearest count.
- R5: In scheme II, the magnitude is 0 below 3277, 1 below 9830, 2 below 22938, 1 below 29491, and 0 from there on.
- R6: In scheme III, the magnitude is 0 below 2731, 1 below 8192, 2 below 24576, 1 below 30037, and 0 from there on.
- R7: For phases below 32768, the level equals the magnitude. The level code is 3-bit two's complement (+2=010, +1=001, 0=000, -1=111, -2=110).
- R8: For phases of 32768 and above, the level is the negated magnitude of r, so the second half mirrors the first.
- R9: The gate word, with bit 5 driving device 1 and bit 0 driving device 6, is 110000 for level 0, 101010 for +1, 101001 for +2, 010110 for -1 and 010101 for -2.
- R10: While running, exactly three gates are on for any non-zero level, and exactly two are on at level 0.
- R11: The scheme select (00=I, 01=II, 10=III, 11 read as I) is loaded while the block is idle and on the cycle the phase wraps through 0. At any other point a change has no effect on the running period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low parks the phase and turns all gates off |
| ftw_i | input | 16 | Phase increment added on each running cycle |
| scheme_i | input | 2 | Timing scheme select |
| gate_o | output | 6 | Gate drive word, bit 5 = device 1 |
| level_o | output | 3 | Current output level, two's complement |

## Verification
The bench steps the phase onto the count just below each level boundary, then onto the boundary itself and the count above it. It does this in both half-cycles and across the wrap for all three schemes. A boundary rounded the wrong way, or compared with the wrong inequality, shows up as one step of the wrong gate word. A scheme change made in mid-period must not take effect until the wrap; a design that applied it at once would switch levels at the wrong angle for the rest of that period. Other cases drop the enable while running and use an odd tuning word that wraps many times. A design that failed to clear the gates, failed to restart at angle 0, or lost the carry at the wrap would break the clock-by-clock comparison with the reference model.

// File: rtl/stair_pkg.sv
package stair_pkg;

  typedef enum logic [1:0] {
    SCH_I   = 2'd0,
    SCH_II  = 2'd1,
    SCH_III = 2'd2
  } scheme_e;

  localparam int NUM_SCHEMES = 3;
  localparam int GATE_W      = 6;
  localparam int LVL_W       = 3;

  // unit angle in degrees per scheme
  function automatic int unit_deg(input int s);
    case (s)
      1:       return 18;
      2:       return 15;
      default: return 30;
    endcase
  endfunction

  // length of each one-step segment, in units
  function automatic int side_units(input int s);
    return (s == 0) ? 1 : 2;
  endfunction

  // length of the centre two-step segment, in units
  function automatic int centre_units(input int s);
    case (s)
      1:       return 4;
      2:       return 6;
      default: return 2;
    endcase
  endfunction

  // k-th level edge (1..4) within a half-cycle, in degrees
  function automatic int edge_deg(input int s, input int k);
    int u;
    u = unit_deg(s);
    case (k)
      1:       return u;
      2:       return u * (1 + side_units(s));
      3:       return u * (1 + side_units(s) + centre_units(s));
      default: return u * (1 + 2 * side_units(s) + centre_units(s));
    endcase
  endfunction

  // degrees to phase counts, 360 degrees = 2^pw, rounded to nearest
  function automatic longint deg_to_count(input int deg, input int pw);
    return ((longint'(deg) << pw) + 64'sd180) / 64'sd360;
  endfunction

  function automatic scheme_e decode_sel(input logic [1:0] s);
    case (s)
      2'd1:    return SCH_II;
      2'd2:    return SCH_III;
      default: return SCH_I;
    endcase
  endfunction

  // level to gate word, bit 5 = device 1 ... bit 0 = device 6
  function automatic logic [GATE_W-1:0] switch_word(input logic signed [LVL_W-1:0] lvl);
    case (lvl)
      3'b001:  return 6'b101010;
      3'b010:  return 6'b101001;
      3'b111:  return 6'b010110;
      3'b110:  return 6'b010101;
      default: return 6'b110000;
    endcase
  endfunction

endpackage

// File: rtl/stair_phase_acc.sv
module stair_phase_acc
  import stair_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [PW-1:0] ftw_i,
  input  logic [1:0]    sel_i,
  output logic [PW-1:0] phase_o,
  output scheme_e       scheme_o,
  output logic          run_o,
  output logic          wrap_o
);

  logic [PW:0] sum;

  assign sum    = {1'b0, phase_o} + {1'b0, ftw_i};
  assign wrap_o = run_o & en & sum[PW];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_o  <= '0;
      scheme_o <= SCH_I;
      run_o    <= 1'b0;
    end else begin
      run_o <= en;
      if (!en)        phase_o <= '0;
      else if (run_o) phase_o <= sum[PW-1:0];
      if (!run_o || wrap_o) scheme_o <= decode_sel(sel_i);
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (run_o && en) |=> (PW'(phase_o - $past(phase_o)) == $past(ftw_i))); // R3

  AST_IDLE_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    !en |=> (phase_o == '0)); // R2

  AST_SCHEME_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run_o && !wrap_o) |=> $stable(scheme_o)); // R11

endmodule

// File: rtl/stair_level_map.sv
module stair_level_map
  import stair_pkg::*;
#(
  parameter int PW = 16
) (
  input  logic [PW-1:0]           phase_i,
  input  scheme_e                 scheme_i,
  output logic signed [LVL_W-1:0] level_o,
  output logic                    neg_half_o
);

  localparam int OW = PW - 1;

  logic [OW-1:0]                   off;
  logic [NUM_SCHEMES-1:0][1:0]     mag_s;
  logic [1:0]                      mag;

  assign off        = phase_i[OW-1:0];
  assign neg_half_o = phase_i[PW-1];

  for (genvar s = 0; s < NUM_SCHEMES; s++) begin : g_sch
    localparam logic [OW-1:0] T1 = OW'(deg_to_count(edge_deg(s, 1), PW));
    localparam logic [OW-1:0] T2 = OW'(deg_to_count(edge_deg(s, 2), PW));
    localparam logic [OW-1:0] T3 = OW'(deg_to_count(edge_deg(s, 3), PW));
    localparam logic [OW-1:0] T4 = OW'(deg_to_count(edge_deg(s, 4), PW));
    assign mag_s[s] = (off < T1) ? 2'd0 :
                      (off < T2) ? 2'd1 :
                      (off < T3) ? 2'd2 :
                      (off < T4) ? 2'd1 : 2'd0;
  end

  always_comb begin
    case (scheme_i)
      SCH_II:  mag = mag_s[1];
      SCH_III: mag = mag_s[2];
      default: mag = mag_s[0];
    endcase
  end

  assign level_o = neg_half_o ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

endmodule

// File: rtl/stair_gate_dec.sv
module stair_gate_dec
  import stair_pkg::*;
(
  input  logic                    run_i,
  input  logic signed [LVL_W-1:0] level_i,
  output logic [GATE_W-1:0]       gate_o
);

  assign gate_o = run_i ? switch_word(level_i) : '0;

endmodule

// File: rtl/staircase_gate_gen.sv
module staircase_gate_gen
  import stair_pkg::*;
#(
  parameter int PHASE_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PHASE_W-1:0] ftw_i,
  input  logic [1:0]         scheme_i,
  output logic [5:0]         gate_o,
  output logic [2:0]         level_o
);

  logic [PHASE_W-1:0]      phase;
  scheme_e                 scheme;
  logic                    run;
  logic                    wrap;
  logic signed [LVL_W-1:0] level;
  logic                    neg_half;

  stair_phase_acc #(.PW(PHASE_W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .ftw_i    (ftw_i),
    .sel_i    (scheme_i),
    .phase_o  (phase),
    .scheme_o (scheme),
    .run_o    (run),
    .wrap_o   (wrap)
  );

  stair_level_map #(.PW(PHASE_W)) u_map (
    .phase_i    (phase),
    .scheme_i   (scheme),
    .level_o    (level),
    .neg_half_o (neg_half)
  );

  stair_gate_dec u_dec (
    .run_i   (run),
    .level_i (level),
    .gate_o  (gate_o)
  );

  assign level_o = run ? level : '0;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (gate_o == '0 && level_o == '0)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gate_o == '0)); // R2

  AST_POS_HALF: assert property (@(posedge clk) disable iff (rst)
    (run && !neg_half) |-> ($signed(level_o) >= 0)); // R7

  AST_NEG_HALF: assert property (@(posedge clk) disable iff (rst)
    (run && neg_half) |-> ($signed(level_o) <= 0)); // R8

  AST_THREE_ON: assert property (@(posedge clk) disable iff (rst)
    (run && level_o != '0) |-> ($countones(gate_o) == 3)); // R10

  AST_TWO_ON: assert property (@(posedge clk) disable iff (rst)
    (run && level_o == '0) |-> ($countones(gate_o) == 2)); // R10

endmodule

// File: tb/sim_staircase_gate_gen.sv
module sim_staircase_gate_gen;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] ftw = '0;
  logic [1:0]  sel = '0;
  logic [5:0]  gate_o;
  logic [2:0]  level_o;

  int    checks   = 0;
  int    failures = 0;
  bit    started  = 0;
  bit    done     = 0;
  string tag      = "R1";

  // reference model state
  int m_phase = 0;
  int m_sch   = 0;
  int m_run   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  staircase_gate_gen u0 (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .ftw_i    (ftw),
    .scheme_i (sel),
    .gate_o   (gate_o),
    .level_o  (level_o)
  );

  function automatic int edge_count(input int deg);
    return $rtoi(real'(deg) * 65536.0 / 360.0 + 0.5);
  endfunction

  function automatic int edge_of(input int sch, input int k);
    int d[4];
    case (sch)
      1:       d = '{18, 54, 126, 162};
      2:       d = '{15, 45, 135, 165};
      default: d = '{30, 60, 120, 150};
    endcase
    return edge_count(d[k]);
  endfunction

  function automatic int exp_level(input int ph, input int sch);
    int r, mag;
    r = ph % 32768;
    if      (r < edge_of(sch, 0)) mag = 0;
    else if (r < edge_of(sch, 1)) mag = 1;
    else if (r < edge_of(sch, 2)) mag = 2;
    else if (r < edge_of(sch, 3)) mag = 1;
    else                          mag = 0;
    return (ph >= 32768) ? -mag : mag;
  endfunction

  function automatic logic [5:0] exp_word(input int lvl);
    case (lvl)
      1:       return 6'b101010;
      2:       return 6'b101001;
      -1:      return 6'b010110;
      -2:      return 6'b010101;
      default: return 6'b110000;
    endcase
  endfunction

  // reference model: next state from the inputs seen at the edge
  always @(posedge clk) begin
    int sum, nsel;
    started = 1;
    if (rst) begin
      m_phase = 0; m_sch = 0; m_run = 0;
    end else begin
      sum  = m_phase + int'(ftw);
      nsel = (sel == 2'd1) ? 1 : (sel == 2'd2) ? 2 : 0;
      if (m_run == 0 || (en && sum > 65535)) m_sch = nsel;
      if (!en)             m_phase = 0;
      else if (m_run != 0) m_phase = sum % 65536;
      m_run = en ? 1 : 0;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    int         el, gl;
    logic [5:0] eg;
    if (started && !done) begin
      el = (m_run != 0) ? exp_level(m_phase, m_sch) : 0;
      eg = (m_run != 0) ? exp_word(el) : 6'b000000;
      gl = int'($signed(level_o));
      checks++;
      if (gate_o !== eg) begin
        failures++;
        $display("FAIL %s R9 gate phase=%0d sch=%0d got %b expected %b",
                 tag, m_phase, m_sch, gate_o, eg);
      end
      checks++;
      if (gl != el) begin
        failures++;
        $display("FAIL %s R7 level phase=%0d sch=%0d got %0d expected %0d",
                 tag, m_phase, m_sch, gl, el);
      end
      if (m_run != 0) begin
        checks++;
        if ($countones(gate_o) != ((el == 0) ? 2 : 3)) begin
          failures++;
          $display("FAIL R10 devices on got %0d expected %0d",
                   $countones(gate_o), (el == 0) ? 2 : 3);
        end
      end
    end
  end

  task automatic tick(input int f);
    ftw = f[15:0];
    @(posedge clk);
    #1;
  endtask

  task automatic restart(input int s);
    sel = s[1:0];
    en  = 1'b0;
    tick(0);
    en  = 1'b1;
    tick(0);
  endtask

  // land on edge-1, edge, edge+1 for every edge of one scheme
  task automatic probe_scheme(input int s, input string t);
    int pts[10];
    tag = t;
    restart(s);
    for (int k = 0; k < 4; k++) begin
      pts[k]     = edge_of(s, k);
      pts[k + 5] = 32768 + edge_of(s, k);
    end
    pts[4] = 32768;
    pts[9] = 65536;
    for (int i = 0; i < 10; i++) begin
      int f;
      f = pts[i] - 1 - m_phase;
      if (f > 0) tick(f);
      tick(1);
      tick(1);
    end
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    rst = 1'b1; en = 1'b0;
    repeat (3) tick(0);
    rst = 1'b0;
    tick(0);

    probe_scheme(0, "R4 R8");
    probe_scheme(1, "R5 R8");
    probe_scheme(2, "R6 R8");

    // full sweeps per scheme
    tag = "R7 R9";
    for (int s = 0; s < 3; s++) begin
      restart(s);
      repeat (700) tick(97);
    end

    // odd tuning word with frequent wraps
    tag = "R3";
    restart(2);
    repeat (200) tick(40961);

    // deferred scheme change, then select 11 read as scheme I
    tag = "R11";
    restart(0);
    repeat (200) tick(97);
    sel = 2'd1;
    repeat (700) tick(97);
    sel = 2'd3;
    repeat (700) tick(97);

    // enable dropped in mid-run
    tag = "R2";
    restart(2);
    repeat (150) tick(113);
    en = 1'b0;
    repeat (5) tick(113);
    en = 1'b1;
    repeat (100) tick(113);

    // reset in mid-run
    tag = "R1";
    rst = 1'b1;
    repeat (2) tick(97);
    rst = 1'b0;
    repeat (20) tick(97);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog run hung got timeout expected finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule